// File: doc/BRIEF.md
# Programmable PLL Channel Clock-Enable Divider

This block sits behind one output channel of a PLL and turns the parent PLL clock into a divided clock-enable stream. Downstream logic runs on the parent clock and uses the enable to advance once per divided period. The division ratio is the product of two parts. The first is an 8-bit programmable divide value, where a programmed zero means the largest value the field can hold. The second is a fixed post-divider that each instance sets through a parameter.

Three conditions can stop the output: the channel's own disable bit, a hold bit taken from the parent PLL's shared control register, and the loss of the parent's lock indication. All three arrive from other logic, so each passes through a synchronizer in the parent clock domain before the block uses it. The `active` flag reports that the output is running. A new divide value is picked up only at the end of a period, so the block never emits a short period.

Top module: `pll_chan_div`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `clk_en` and `active` are both 0.
- R2: While `active` is 1, `clk_en` is high for exactly one cycle in every N cycles, where N = D * FIXED_DIV and D is the programmed divide value.
- R3: A `div_val` of zero is treated as D = 2^DIV_W - 1, which is 255 for the default width.
- R4: The fixed post-divider FIXED_DIV multiplies the programmed ratio. With FIXED_DIV = 3 and D = 4, a pulse comes every 12 cycles.
- R5: While the synchronized `chan_disable` is 1, `clk_en` stays 0 and `active` is 0.
- R6: While the synchronized `chan_hold` is 1, `clk_en` stays 0 and `active` is 0.
- R7: While the synchronized `pll_locked` is 0, `clk_en` stays 0 and `active` is 0.
- R8: If `div_val` changes while the output is running, the period already in progress completes with the old ratio, and the following period uses the new one.
- R9: The three control inputs each pass through SYNC_STAGES flip-flops (default 2). Once the output becomes able to run, `active` rises SYNC_STAGES cycles after the change, and the first `clk_en` pulse appears SYNC_STAGES + N cycles after the change.
- R10: `active` is 1 exactly when the synchronized lock is 1, the synchronized disable is 0 and the synchronized hold is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | The parent PLL is locked and running |
| div_val | input | DIV_W | Programmed divide value (0 means maximum) |
| chan_disable | input | 1 | Channel disable bit |
| chan_hold | input | 1 | Channel hold bit from the shared PLL control register |
| clk_en | output | 1 | Single-cycle enable, once per divided period |
| active | output | 1 | The channel output is running |

## Verification
A change on a control input appears on `active` exactly SYNC_STAGES rising edges later. The first enable pulse follows N edges after that. The bench drives every input at a falling edge and then counts rising edges, sampling at each falling edge, until the pulse appears. It compares that count with SYNC_STAGES + N, and it compares the gap between consecutive pulses with N. For a divide change made while the output runs, the bench applies the new value on the falling edge just after a pulse. It then expects one more gap with the old N before the gaps switch to the new N.

// File: rtl/pll_chan_pkg.sv
package pll_chan_pkg;

  // Effective division ratio: a zero field selects the maximum, and the
  // fixed post-divider multiplies the result.
  function automatic logic [31:0] chan_ratio(input logic [31:0] div,
                                             input logic [31:0] div_max,
                                             input logic [31:0] fixed);
    logic [31:0] d;
    d = (div == 32'd0) ? div_max : div;
    return d * fixed;
  endfunction

endpackage

// File: rtl/pll_chan_sync.sv
module pll_chan_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pll_chan_period.sv
module pll_chan_period #(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] ratio_next,
  output logic          pulse,
  output logic          wrap,
  output logic [RW-1:0] cnt,
  output logic [RW-1:0] ratio_q
);

  // The period ends in the cycle where the count reaches the ratio less one.
  assign wrap = run && (cnt == ratio_q - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ratio_q <= RW'(1);
      pulse   <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      ratio_q <= ratio_next;
      pulse   <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      ratio_q <= ratio_next;
      pulse   <= 1'b1;
    end else begin
      cnt     <= cnt + RW'(1);
      pulse   <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_chan_div.sv
module pll_chan_div #(
  parameter int DIV_W       = 8,
  parameter int FIXED_DIV   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_locked,
  input  logic [DIV_W-1:0] div_val,
  input  logic             chan_disable,
  input  logic             chan_hold,
  output logic             clk_en,
  output logic             active
);

  import pll_chan_pkg::*;

  localparam int RW      = DIV_W + $clog2(FIXED_DIV + 1);
  localparam int DIV_MAX = (1 << DIV_W) - 1;

  logic [2:0]    ctl_s;
  logic          run;
  logic          wrap;
  logic          pulse;
  logic [RW-1:0] cnt;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] ratio_next;

  pll_chan_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pll_locked, chan_disable, chan_hold}),
    .q    (ctl_s)
  );

  // ctl_s[2] = locked, ctl_s[1] = disable, ctl_s[0] = hold
  assign run = ctl_s[2] && !ctl_s[1] && !ctl_s[0];

  assign ratio_next = RW'(chan_ratio(32'(div_val), 32'(DIV_MAX), 32'(FIXED_DIV)));

  pll_chan_period #(.RW(RW)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ratio_next(ratio_next),
    .pulse     (pulse),
    .wrap      (wrap),
    .cnt       (cnt),
    .ratio_q   (ratio_q)
  );

  assign clk_en = pulse && run;
  assign active = run;

endmodule

// File: rtl/pll_chan_div_chk.sv
module pll_chan_div_chk #(
  parameter int RW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          active,
  input logic          wrap,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] ratio_q
);

  // R2
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ratio_q > RW'(1)) |=> !clk_en);

  // R5
  gated_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !clk_en);

  // R8
  ratio_held_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wrap) |=> $stable(ratio_q));

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio_q);

  // R3
  ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q != '0);

endmodule

bind pll_chan_div pll_chan_div_chk #(.RW(RW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clk_en (clk_en),
  .active (active),
  .wrap   (wrap),
  .cnt    (cnt),
  .ratio_q(ratio_q)
);

// File: tb/pll_chan_div_test.sv
module pll_chan_div_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int FIXED      = 3;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pll_locked = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic             chan_disable = 1'b1;
  logic             chan_hold = 1'b0;
  logic             clk_en;
  logic             active;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  pll_chan_div #(.DIV_W(DIV_W), .FIXED_DIV(FIXED), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .div_val(div_val),
    .chan_disable(chan_disable), .chan_hold(chan_hold),
    .clk_en(clk_en), .active(active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_ratio(int d);
    return ((d == 0) ? ((1 << DIV_W) - 1) : d) * FIXED;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Cycles (rising edges, sampled at falling edges) until clk_en is seen.
  task automatic wait_pulse(int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!clk_en && n < limit);
  endtask

  // Count pulses over a window of cycles.
  task automatic count_pulses(int len, output int p);
    p = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (clk_en) p++;
    end
  endtask

  task automatic idle(int len);
    for (int i = 0; i < len; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    int p;
    int r;
    idle(3);
    // R1: reset state
    check("R1 clk_en in reset", int'(clk_en), 0);
    check("R1 active in reset", int'(active), 0);
    rst_n = 1'b1;
    pll_locked = 1'b1;
    @(negedge clk);
    check("R1 clk_en after release", int'(clk_en), 0);
    check("R1 active after release", int'(active), 0);
    idle(4);

    // R2 R3 R4 R9: sweep divide values, including zero
    for (int d = 0; d <= 20; d++) begin
      r = exp_ratio(d);
      div_val = DIV_W'(d);
      idle(1);
      chan_disable = 1'b0;
      wait_pulse(r + 20, n);
      check("R9 first pulse latency", n, SYNC + r);
      wait_pulse(r + 20, n);
      check((d == 0) ? "R3 zero divide period" : "R4 period", n, r);
      wait_pulse(r + 20, n);
      check("R2 period repeat", n, r);
      check("R10 active while running", int'(active), 1);
      chan_disable = 1'b1;
      idle(SYNC + 2);
    end

    // R9 R10: active rises exactly SYNC cycles after enable
    div_val = 8'd4;
    idle(1);
    chan_disable = 1'b0;
    for (int i = 0; i < SYNC - 1; i++) begin
      @(posedge clk); @(negedge clk);
    end
    check("R9 active not yet", int'(active), 0);
    @(posedge clk); @(negedge clk);
    check("R9 active at sync depth", int'(active), 1);

    // R5: disable suppresses output
    wait_pulse(40, n);
    chan_disable = 1'b1;
    idle(SYNC);
    check("R5 active low when disabled", int'(active), 0);
    count_pulses(100, p);
    check("R5 pulses while disabled", p, 0);
    chan_disable = 1'b0;
    wait_pulse(40, n);
    check("R5 restart latency", n, SYNC + 12);

    // R6: hold suppresses output
    chan_hold = 1'b1;
    idle(SYNC);
    check("R6 active low when held", int'(active), 0);
    count_pulses(100, p);
    check("R6 pulses while held", p, 0);
    chan_hold = 1'b0;
    wait_pulse(40, n);
    check("R6 restart latency", n, SYNC + 12);

    // R7: lock loss stops output
    pll_locked = 1'b0;
    idle(SYNC);
    check("R7 active low when unlocked", int'(active), 0);
    count_pulses(100, p);
    check("R7 pulses while unlocked", p, 0);
    pll_locked = 1'b1;
    wait_pulse(40, n);
    check("R7 restart latency", n, SYNC + 12);

    // R8: divide change takes effect at the period boundary
    div_val = 8'd5;
    wait_pulse(40, n);
    check("R8 old ratio period", n, 12);
    div_val = 8'd2;
    wait_pulse(40, n);
    check("R8 period in progress keeps old", n, 15);
    wait_pulse(40, n);
    check("R8 new ratio applied", n, 6);
    div_val = 8'd7;
    wait_pulse(40, n);
    check("R8 second change old", n, 6);
    wait_pulse(40, n);
    check("R8 second change new", n, 21);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule